// File: doc/BRIEF.md
# Element Gather Permutation Unit

This block is a one-cycle execution unit for a 32-bit load-store core. It produces a result word by gathering elements of the first operand: every element of the second operand is read as an index, and the element of the first operand at that index is placed in the same position of the result. An index that points past the end of the 32-bit word gives a zero element. Three element sizes are offered (4, 8 and 16 bits), picked by decoding the instruction word that comes with the operands.

An instruction that matches none of the three forms still produces a result cycle, but with the illegal flag raised and a zero result, so the issuing pipeline can trap. The result, its valid flag and the illegal flag are all registered; a small two-state controller tracks whether a result is currently presented. The state `ST_EMPTY` means no result is presented; `ST_PRESENT` means a result is on the output. The transition `ST_EMPTY -> ST_PRESENT` is taken on an accepted input, `ST_PRESENT -> ST_PRESENT` on a back-to-back input, `ST_PRESENT -> ST_EMPTY` on a cycle with no input, and `ST_EMPTY -> ST_EMPTY` otherwise. Reset forces `ST_EMPTY`.

Top module: `elem_gather_unit`

## Requirements
- R1: A synchronous active-high reset sets `res` to 0, `res_valid` to 0 and `illegal` to 0 on the next clock edge, whatever the other inputs are.
- R2: `res_valid` is 1 in the cycle after a cycle in which `in_valid` was 1 and 0 after a cycle in which it was 0; `res` keeps its value across cycles without `in_valid`.
- R3: An instruction is accepted when bits [6:0] equal 7'b0110011 and bits [31:25] equal 7'b0010100; bits [14:12] equal to 3'd2, 3'd4 or 3'd6 select 4-bit, 8-bit or 16-bit elements. Bits [24:15] and [11:7] have no effect on the result.
- R4: With 4-bit elements, result bits [4i+3:4i] (i = 0..7) equal `opa` bits [4k+3:4k], where k is `opb` bits [4i+3:4i]; when k is 8 or more the result element is 0.
- R5: With 8-bit elements, result byte i (i = 0..3) equals byte k of `opa`, k being byte i of `opb`; a k of 0 to 3 selects a byte, a k of 4 to 255 gives 0.
- R6: With 16-bit elements, result halfword i (i = 0..1) equals halfword k of `opa`, k being halfword i of `opb`; a k of 0 or 1 selects a halfword, any larger k gives 0.
- R7: An accepted input whose instruction matches none of the three forms gives `illegal` = 1 and `res` = 0 in the next cycle; `illegal` is 0 in every cycle where `res_valid` is 0 and for every legal form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and instruction are presented this cycle |
| instr | input | 32 | Instruction word to decode |
| opa | input | 32 | Source operand that elements are gathered from |
| opb | input | 32 | Operand holding the element indices |
| res | output | 32 | Registered gathered result |
| res_valid | output | 1 | A result is presented this cycle |
| illegal | output | 1 | The presented result came from a non-matching instruction |

## Verification
The properties take for granted that reset is held from time zero through the first clock edges and that `in_valid`, `instr` and `opb` carry defined values on every edge after reset, since the out-of-range and decode checks read those inputs one cycle before the outputs they constrain. The stimulus therefore starts inside reset, drives every input to a known value on the falling edge only, and never leaves an input undriven. Index operands are biased toward the edge of the word (indices just below and just above the element count) so the zeroing rule is reached often, and the instruction's register fields are randomised to exercise the ignored bits.

// File: rtl/egu_pkg.sv
`timescale 1ns/1ps
package egu_pkg;

    localparam int XLEN = 32;

    localparam logic [6:0] OPC_REG  = 7'b0110011;
    localparam logic [6:0] F7_GATH  = 7'b0010100;
    localparam logic [2:0] F3_NIB   = 3'd2;
    localparam logic [2:0] F3_BYTE  = 3'd4;
    localparam logic [2:0] F3_HALF  = 3'd6;

    localparam int NUM_SIZES = 3;
    localparam int MIN_LOG2E = 2;

    typedef enum logic [1:0] {
        GM_NIB  = 2'd0,
        GM_BYTE = 2'd1,
        GM_HALF = 2'd2,
        GM_NONE = 2'd3
    } gath_mode_e;

    typedef enum logic {
        ST_EMPTY   = 1'b0,
        ST_PRESENT = 1'b1
    } egu_state_e;

endpackage

// File: rtl/egu_decode.sv
`timescale 1ns/1ps
module egu_decode
    import egu_pkg::*;
(
    input  logic [6:0] f7,
    input  logic [2:0] f3,
    input  logic [6:0] opc,
    output gath_mode_e mode
);

    logic base_hit;

    assign base_hit = (opc == OPC_REG) && (f7 == F7_GATH);

    always_comb begin
        mode = GM_NONE;
        if (base_hit) begin
            unique case (f3)
                F3_NIB:  mode = GM_NIB;
                F3_BYTE: mode = GM_BYTE;
                F3_HALF: mode = GM_HALF;
                default: mode = GM_NONE;
            endcase
        end
    end

endmodule

// File: rtl/egu_lane_gather.sv
`timescale 1ns/1ps
module egu_lane_gather #(
    parameter int W     = 32,
    parameter int LOG2E = 2
) (
    input  logic [W-1:0] src,
    input  logic [W-1:0] idx_word,
    output logic [W-1:0] dst
);

    localparam int EW = 1 << LOG2E;
    localparam int NL = W / EW;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic [EW-1:0] idx;
        logic [EW-1:0] sel;

        assign idx = idx_word[i*EW +: EW];

        always_comb begin
            sel = '0;
            for (int j = 0; j < NL; j++) begin
                if (idx == EW'(j)) begin
                    sel = src[j*EW +: EW];
                end
            end
        end

        assign dst[i*EW +: EW] = sel;
    end

endmodule

// File: rtl/elem_gather_unit.sv
`timescale 1ns/1ps
module elem_gather_unit
    import egu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic [XLEN-1:0] res,
    output logic            res_valid,
    output logic            illegal
);

    gath_mode_e      mode;
    egu_state_e      state_q;
    egu_state_e      state_d;
    logic [XLEN-1:0] gathered [NUM_SIZES];
    logic [XLEN-1:0] picked;
    logic            unused_fields;

    assign unused_fields = ^{instr[24:15], instr[11:7]};

    egu_decode u_dec (
        .f7   (instr[31:25]),
        .f3   (instr[14:12]),
        .opc  (instr[6:0]),
        .mode (mode)
    );

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        egu_lane_gather #(
            .W     (XLEN),
            .LOG2E (MIN_LOG2E + g)
        ) u_gath (
            .src      (opa),
            .idx_word (opb),
            .dst      (gathered[g])
        );
    end

    always_comb begin
        unique case (mode)
            GM_NIB:  picked = gathered[0];
            GM_BYTE: picked = gathered[1];
            GM_HALF: picked = gathered[2];
            default: picked = '0;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_EMPTY:   state_d = in_valid ? ST_PRESENT : ST_EMPTY;
            ST_PRESENT: state_d = in_valid ? ST_PRESENT : ST_EMPTY;
            default:    state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res     <= '0;
            illegal <= 1'b0;
        end else if (in_valid) begin
            res     <= picked;
            illegal <= (mode == GM_NONE);
        end else begin
            illegal <= 1'b0;
        end
    end

    assign res_valid = (state_q == ST_PRESENT);

endmodule

// File: rtl/egu_checker.sv
`timescale 1ns/1ps
module egu_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] instr,
    input logic [31:0] opb,
    input logic [31:0] res,
    input logic        res_valid,
    input logic        illegal
);

    logic base_ok;
    logic unused_chk;

    assign unused_chk = ^{instr[24:15], instr[11:7], opb[31:16]};
    assign base_ok    = (instr[6:0] == 7'b0110011) && (instr[31:25] == 7'b0010100);

    assert_valid_next_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_valid);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!res_valid && $stable(res)));

    assert_illegal_zero_R7: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (res_valid && res == 32'd0));

    assert_bad_opcode_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[6:0] != 7'b0110011) |=> illegal);

    assert_byte_oob_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && base_ok && instr[14:12] == 3'd4 && opb[7:0] >= 8'd4)
        |=> (res[7:0] == 8'd0 && !illegal));

    assert_half_oob_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && base_ok && instr[14:12] == 3'd6 && opb[15:0] >= 16'd2)
        |=> (res[15:0] == 16'd0 && !illegal));

endmodule

bind elem_gather_unit egu_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .instr     (instr),
    .opb       (opb),
    .res       (res),
    .res_valid (res_valid),
    .illegal   (illegal)
);

// File: tb/sim_elem_gather_unit.sv
`timescale 1ns/1ps
module sim_elem_gather_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] instr = 32'd0;
    logic [31:0] opa = 32'd0;
    logic [31:0] opb = 32'd0;
    logic [31:0] res;
    logic        res_valid;
    logic        illegal;

    int total = 0;
    int bad = 0;

    logic [31:0] exp_res = 32'd0;
    logic        exp_valid = 1'b0;
    logic        exp_ill = 1'b0;

    localparam logic [31:0] I_NIB  = 32'h28002033;
    localparam logic [31:0] I_BYTE = 32'h28004033;
    localparam logic [31:0] I_HALF = 32'h28006033;

    always #10 clk = ~clk;

    elem_gather_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .opa(opa), .opb(opb), .res(res), .res_valid(res_valid), .illegal(illegal)
    );

    // returns {illegal, result}
    function automatic logic [32:0] ref_op(logic [31:0] ins, logic [31:0] a, logic [31:0] b);
        int lg;
        longint sz, msk, idx, pos;
        longint r;
        if (ins[6:0] != 7'h33 || ins[31:25] != 7'h14) return {1'b1, 32'd0};
        case (ins[14:12])
            3'd2: lg = 2;
            3'd4: lg = 3;
            3'd6: lg = 4;
            default: return {1'b1, 32'd0};
        endcase
        sz  = 64'd1 << lg;
        msk = (64'd1 << sz) - 1;
        r   = 0;
        for (int i = 0; i < 32; i += int'(sz)) begin
            idx = (longint'(b) >> i) & msk;
            pos = idx << lg;
            if (pos < 32) r = r | (((longint'(a) >> pos) & msk) << i);
        end
        return {1'b0, r[31:0]};
    endfunction

    task automatic compare(string tag);
        total++;
        if (res !== exp_res || res_valid !== exp_valid || illegal !== exp_ill) begin
            bad++;
            $display("FAIL %s: res=%h valid=%b ill=%b expected res=%h valid=%b ill=%b",
                     tag, res, res_valid, illegal, exp_res, exp_valid, exp_ill);
        end
    endtask

    // drive at negedge, model at posedge, compare at next negedge
    task automatic step(logic v, logic [31:0] ins, logic [31:0] a, logic [31:0] b, string tag);
        logic [32:0] m;
        in_valid = v; instr = ins; opa = a; opb = b;
        @(posedge clk);
        if (rst) begin
            exp_res = 32'd0; exp_valid = 1'b0; exp_ill = 1'b0;
        end else if (v) begin
            m = ref_op(ins, a, b);
            exp_res = m[31:0]; exp_ill = m[32]; exp_valid = 1'b1;
        end else begin
            exp_valid = 1'b0; exp_ill = 1'b0;
        end
        @(negedge clk);
        compare(tag);
    endtask

    function automatic logic [31:0] rand_fields(logic [31:0] base);
        logic [31:0] f;
        f = $urandom;
        return base | {7'd0, f[24:15], 3'd0, f[11:7], 7'd0};
    endfunction

    function automatic logic [31:0] biased_idx(int lg);
        logic [31:0] w = 32'd0;
        int esz = 1 << lg;
        int nl = 32 >> lg;
        for (int i = 0; i < 32; i += esz) begin
            int k = (($urandom % 4) == 0) ? int'($urandom) : int'($urandom % (nl + 2));
            w = w | ((32'(k) & ((32'd1 << esz) - 1)) << i);
        end
        return w;
    endfunction

    initial begin
        #(20 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset with busy inputs
        rst = 1'b1;
        step(1'b1, 32'hFFFF_FFFF, 32'h1234_5678, 32'h0, "R1");
        step(1'b1, I_BYTE, 32'hDEAD_BEEF, 32'h0, "R1");
        rst = 1'b0;
        step(1'b0, 32'd0, 32'd0, 32'd0, "R1");

        // R4 nibble edge cases
        step(1'b1, I_NIB, 32'h89AB_CDEF, 32'h0000_0000, "R4");
        step(1'b1, I_NIB, 32'h89AB_CDEF, 32'hFFFF_FFFF, "R4");
        step(1'b1, I_NIB, 32'h89AB_CDEF, 32'h7654_3210, "R4");
        step(1'b1, I_NIB, 32'h89AB_CDEF, 32'h0123_4567, "R4");
        step(1'b1, I_NIB, 32'h89AB_CDEF, 32'h8877_9900, "R4");
        // R5 byte edge cases
        step(1'b1, I_BYTE, 32'h1122_3344, 32'h0000_0000, "R5");
        step(1'b1, I_BYTE, 32'h1122_3344, 32'hFFFF_FFFF, "R5");
        step(1'b1, I_BYTE, 32'h1122_3344, 32'h0302_0100, "R5");
        step(1'b1, I_BYTE, 32'h1122_3344, 32'h0405_0300, "R5");
        // R6 halfword edge cases
        step(1'b1, I_HALF, 32'hCAFE_F00D, 32'h0000_0000, "R6");
        step(1'b1, I_HALF, 32'hCAFE_F00D, 32'hFFFF_FFFF, "R6");
        step(1'b1, I_HALF, 32'hCAFE_F00D, 32'h0001_0000, "R6");
        step(1'b1, I_HALF, 32'hCAFE_F00D, 32'h0000_0001, "R6");
        step(1'b1, I_HALF, 32'hCAFE_F00D, 32'h0002_0001, "R6");

        // R2: idle cycles hold the result
        step(1'b0, I_NIB, 32'h0, 32'h0, "R2");
        step(1'b0, 32'h0, 32'hFFFF_FFFF, 32'h1, "R2");
        step(1'b1, I_BYTE, 32'hA1B2_C3D4, 32'h0001_0203, "R2");
        step(1'b0, I_BYTE, 32'h0, 32'h0, "R2");

        // R7: non-matching forms
        step(1'b1, 32'h28000033, 32'h1234_5678, 32'h0, "R7");
        step(1'b1, 32'h28008033, 32'h1234_5678, 32'h0, "R7");
        step(1'b1, 32'h28004013, 32'h1234_5678, 32'h0, "R7");
        step(1'b1, 32'h2A004033, 32'h1234_5678, 32'h0, "R7");
        step(1'b1, 32'h68004033, 32'h1234_5678, 32'h0, "R7");
        step(1'b1, I_BYTE, 32'h1234_5678, 32'h0001_0203, "R7");

        // R3: register fields randomised, random operands
        for (int n = 0; n < 60; n++) begin
            step(1'b1, rand_fields(I_NIB), $urandom, biased_idx(2), "R3");
            step(1'b1, rand_fields(I_BYTE), $urandom, biased_idx(3), "R3");
            step(1'b1, rand_fields(I_HALF), $urandom, biased_idx(4), "R3");
        end

        // random mix of sizes, idle cycles and bad instructions
        for (int n = 0; n < 300; n++) begin
            int pick = int'($urandom % 5);
            case (pick)
                0: step(1'b1, I_NIB, $urandom, biased_idx(2), "R4");
                1: step(1'b1, I_BYTE, $urandom, biased_idx(3), "R5");
                2: step(1'b1, I_HALF, $urandom, biased_idx(4), "R6");
                3: step(1'b0, $urandom, $urandom, $urandom, "R2");
                default: step(1'b1, $urandom, $urandom, $urandom, "R7");
            endcase
        end

        // R1: reset in mid-stream
        rst = 1'b1;
        step(1'b1, I_NIB, 32'hFFFF_FFFF, 32'h0, "R1");
        rst = 1'b0;
        step(1'b0, 32'h0, 32'h0, 32'h0, "R1");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule